// File: doc/BRIEF.md
# Configurable UART Transmitter with LIN Header

This block is the transmit half of a UART. It takes bytes from a valid/ready input and drives them onto a serial line. A set of static configuration inputs controls the framing: the number of data bits, an optional even or odd parity bit, and a stop length counted in half-bit steps. All timing comes from a single-cycle tick input that runs at sixteen times the baud rate. Each bit lasts 16 of these ticks.

Three optional features sit around the basic framer:
- **LIN header.** Before any data, the block can emit a break field of programmable length. A one-bit high delimiter and a 0x55 sync character follow the break.
- **Infrared output.** Each zero bit becomes a short pulse. The polarity of this output can be inverted.
- **CTS flow control.** New characters are held off while CTS is low.

A 16-bit length counter counts the data characters sent. When the programmed number has gone out, it raises a one-cycle end pulse. In free-running mode the length is ignored.

Software raises the enable input to start a transfer. It lowers enable after the transfer is finished, which returns the block to idle.

Top module: `uart_tx_lin`

## Requirements
- R1: Each character is a low start bit of 16 ticks, then (cfg_data_bits + 1) data bits of 16 ticks each, least significant bit first. The field value 7 gives 8 data bits. Between characters, with infrared mode off, the line rests high.
- R2: With cfg_par_en high, one parity bit follows the data bits. cfg_par_odd = 1 gives odd parity over the data bits sent, and 0 gives even parity. With cfg_par_en low, no parity bit is sent.
- R3: The stop level (high) lasts cfg_stop_half × 8 ticks. A field value of 0 is treated as 1.
- R4: With cfg_lin_en high, each enable session starts with a header, sent once, while data input stays blocked:
  - the line low for (cfg_brk_len + 8) × 16 ticks;
  - then high for 16 ticks;
  - then the sync character 0x55 in the configured framing.
- R5: The sync character is not counted. After the cfg_xfer_len-th data character's stop ends, xfer_done is high for one clock. No further character is accepted until enable is cleared. A length of 0 accepts no characters.
- R6: With cfg_free_run high, the length is ignored, characters are accepted without limit, and xfer_done never rises.
- R7: With cfg_cts_en high and cts low, in_ready stays low and no character or header starts. A character already in progress completes in full.
- R8: With cfg_ir_en high, the raw line is reshaped:
  - a zero bit gives a high pulse during ticks 8, 9 and 10 of its bit time, where tick 0 is the first tick of the bit;
  - a one bit gives a low output;
  - cfg_ir_inv inverts the whole output, idle included.
- R9: In reset, and one cycle after cfg_en is low, the line is idle: txd is high with infrared mode off, and in_ready is low. Lowering enable also clears the character count and the header-sent state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the baud rate |
| cfg_en | input | 1 | Transfer enable |
| cfg_lin_en | input | 1 | Send LIN header first |
| cfg_brk_len | input | 3 | Break length minus 8, in bit times |
| cfg_data_bits | input | 3 | Data bits per character minus one |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop_half | input | 2 | Stop length in half bits |
| cfg_cts_en | input | 1 | CTS flow control enable |
| cts | input | 1 | Clear to send, active high |
| cfg_ir_en | input | 1 | Infrared pulse output |
| cfg_ir_inv | input | 1 | Invert infrared output |
| cfg_free_run | input | 1 | Ignore transfer length |
| cfg_xfer_len | input | 16 | Characters per transfer |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Character accepted on this cycle when valid |
| txd | output | 1 | Serial line |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |

## Verification

**Framing.** The bench decodes the line at bit centres for several data widths, down to a single data bit. It checks both parity senses, including all-ones data, where an inverted parity sense shows up at once. It also checks every stop setting, including 0, where a design that multiplied the raw field would stop for zero ticks.

**LIN header.** The break is timed at two lengths, which catches a missing +8 offset. The delimiter is timed as well, and the bench checks that the sync character goes out once and uncounted.

**Length and free-run.** The length test counts xfer_done pulses. An off-by-one counter would pulse after the wrong character or let a fourth character through.

**CTS and infrared.** CTS is dropped in the middle of a character: a design that sampled CTS on every bit would truncate the frame. The infrared pulse is probed on its first and last tick and on both sides of it, so a misplaced or mis-sized pulse changes the samples.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BREAK = 3'd1,
    ST_DELIM = 3'd2,
    ST_START = 3'd3,
    ST_DATA  = 3'd4,
    ST_PAR   = 3'd5,
    ST_STOP  = 3'd6
  } tx_state_e;

endpackage

// File: rtl/uart_tx_len_ctr.sv
module uart_tx_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             char_done,
  input  logic             free_run,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             finished,
  output logic             done_pulse
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (char_done) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = !free_run && ((cnt_q + 1'b1) == xfer_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign finished   = !free_run && (cnt_q >= xfer_len);
  assign done_pulse = done_q;

endmodule

// File: rtl/uart_tx_ir.sv
module uart_tx_ir #(
  parameter int OSR      = 16,
  parameter int IR_TICKS = 3
) (
  input  logic                   raw,
  input  logic [$clog2(OSR)-1:0] phase,
  input  logic                   ir_en,
  input  logic                   ir_inv,
  output logic                   line
);

  localparam int PH_W   = $clog2(OSR);
  localparam int P_LO   = OSR / 2;
  localparam int P_HI   = OSR / 2 + IR_TICKS;

  logic pulse;

  always_comb begin
    pulse = !raw && (32'(phase) >= P_LO) && (32'(phase) < P_HI);
    line  = ir_en ? (pulse ^ ir_inv) : raw;
  end

endmodule

// File: rtl/uart_tx_lin.sv
module uart_tx_lin
  import uart_tx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DBITS_W  = 3,
  parameter int BRK_W    = 3,
  parameter int STOP_W   = 2,
  parameter int LEN_W    = 16,
  parameter int IR_TICKS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    baud_tick,
  input  logic                    cfg_en,
  input  logic                    cfg_lin_en,
  input  logic [BRK_W-1:0]        cfg_brk_len,
  input  logic [DBITS_W-1:0]      cfg_data_bits,
  input  logic                    cfg_par_en,
  input  logic                    cfg_par_odd,
  input  logic [STOP_W-1:0]       cfg_stop_half,
  input  logic                    cfg_cts_en,
  input  logic                    cts,
  input  logic                    cfg_ir_en,
  input  logic                    cfg_ir_inv,
  input  logic                    cfg_free_run,
  input  logic [LEN_W-1:0]        cfg_xfer_len,
  input  logic [(1<<DBITS_W)-1:0] in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    txd,
  output logic                    xfer_done
);

  localparam int DATA_W  = 1 << DBITS_W;
  localparam int PH_W    = $clog2(OSR);
  localparam int BRK_MAX = ((1 << BRK_W) - 1 + 8) * OSR;
  localparam int CNT_W   = $clog2(BRK_MAX + 1);
  localparam logic [DATA_W-1:0] SYNC_PAT = {(DATA_W/2){2'b01}};

  tx_state_e           state_q, state_d;
  logic [CNT_W-1:0]    tick_q, tick_d;
  logic [DBITS_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0]   shift_q, shift_d;
  logic                par_q, par_d;
  logic                hdr_q, hdr_d;
  logic                sync_q, sync_d;
  logic [CNT_W-1:0]    elem_len;
  logic                last_tick;
  logic                cts_ok;
  logic                finished;
  logic                char_done;
  logic                raw_line;

  assign cts_ok   = !cfg_cts_en || cts;
  assign in_ready = cfg_en && (state_q == ST_IDLE) && (hdr_q || !cfg_lin_en)
                    && cts_ok && !finished;

  always_comb begin
    case (state_q)
      ST_BREAK: elem_len = CNT_W'((32'(cfg_brk_len) + 32'd8) * OSR);
      ST_STOP:  elem_len = CNT_W'(((cfg_stop_half == '0) ? 32'd1 : 32'(cfg_stop_half))
                                  * (OSR / 2));
      default:  elem_len = CNT_W'(OSR);
    endcase
    last_tick = baud_tick && (tick_q == elem_len - 1'b1);
  end

  assign char_done = cfg_en && (state_q == ST_STOP) && last_tick && !sync_q;

  always_comb begin
    case (state_q)
      ST_BREAK, ST_START: raw_line = 1'b0;
      ST_DATA:            raw_line = shift_q[0];
      ST_PAR:             raw_line = par_q ^ cfg_par_odd;
      default:            raw_line = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    par_d   = par_q;
    hdr_d   = hdr_q;
    sync_d  = sync_q;
    if (state_q != ST_IDLE && baud_tick) begin
      tick_d = last_tick ? '0 : tick_q + 1'b1;
    end
    if (!cfg_en) begin
      state_d = ST_IDLE;
      tick_d  = '0;
      hdr_d   = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          tick_d = '0;
          if (cfg_lin_en && !hdr_q && cts_ok) begin
            state_d = ST_BREAK;
          end else if (in_valid && in_ready) begin
            state_d = ST_START;
            shift_d = in_data;
            par_d   = 1'b0;
            sync_d  = 1'b0;
          end
        end
        ST_BREAK: if (last_tick) state_d = ST_DELIM;
        ST_DELIM: if (last_tick) begin
          state_d = ST_START;
          shift_d = SYNC_PAT;
          par_d   = 1'b0;
          sync_d  = 1'b1;
          hdr_d   = 1'b1;
        end
        ST_START: if (last_tick) begin
          state_d = ST_DATA;
          bit_d   = '0;
        end
        ST_DATA: if (last_tick) begin
          par_d   = par_q ^ shift_q[0];
          shift_d = shift_q >> 1;
          bit_d   = bit_q + 1'b1;
          if (bit_q == cfg_data_bits) begin
            state_d = cfg_par_en ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR:  if (last_tick) state_d = ST_STOP;
        ST_STOP: if (last_tick) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      hdr_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      par_q   <= par_d;
      hdr_q   <= hdr_d;
      sync_q  <= sync_d;
    end
  end

  uart_tx_len_ctr #(.LEN_W(LEN_W)) len_ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!cfg_en),
    .char_done  (char_done),
    .free_run   (cfg_free_run),
    .xfer_len   (cfg_xfer_len),
    .finished   (finished),
    .done_pulse (xfer_done)
  );

  uart_tx_ir #(.OSR(OSR), .IR_TICKS(IR_TICKS)) ir_i (
    .raw    (raw_line),
    .phase  (tick_q[PH_W-1:0]),
    .ir_en  (cfg_ir_en),
    .ir_inv (cfg_ir_inv),
    .line   (txd)
  );

endmodule

// File: rtl/uart_tx_lin_chk.sv
module uart_tx_lin_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_cts_en,
  input logic cts,
  input logic cfg_free_run,
  input logic cfg_ir_en,
  input logic in_ready,
  input logic txd,
  input logic xfer_done
);

  p_cts_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cts_en && !cts) |-> !in_ready);

  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cfg_ir_en) |=> (cfg_ir_en || txd));

  p_ready_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> cfg_en);

  p_ready_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !cfg_ir_en) |-> txd);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_done_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cfg_free_run) |-> !in_ready);

  p_free_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_free_run) && cfg_free_run) |-> !xfer_done);

endmodule

bind uart_tx_lin uart_tx_lin_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .cfg_cts_en   (cfg_cts_en),
  .cts          (cts),
  .cfg_free_run (cfg_free_run),
  .cfg_ir_en    (cfg_ir_en),
  .in_ready     (in_ready),
  .txd          (txd),
  .xfer_done    (xfer_done)
);

// File: tb/uart_tx_lin_tb_top.sv
module uart_tx_lin_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        baud_tick;
  logic        cfg_en, cfg_lin_en, cfg_par_en, cfg_par_odd;
  logic [2:0]  cfg_brk_len, cfg_data_bits;
  logic [1:0]  cfg_stop_half;
  logic        cfg_cts_en, cts, cfg_ir_en, cfg_ir_inv, cfg_free_run;
  logic [15:0] cfg_xfer_len;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready, txd, xfer_done;

  int n_chk  = 0;
  int n_fail = 0;
  int done_cnt = 0;
  bit finished_run = 0;

  typedef struct packed {
    logic [7:0] data;
    logic [2:0] nb;
    logic       pen;
    logic       podd;
    logic [1:0] stop;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hA5, 3'd7, 1'b0, 1'b0, 2'd1},
    '{8'h3C, 3'd7, 1'b1, 1'b0, 2'd2},
    '{8'h3C, 3'd7, 1'b1, 1'b1, 2'd2},
    '{8'h81, 3'd4, 1'b1, 1'b1, 2'd3},
    '{8'hFF, 3'd6, 1'b1, 1'b0, 2'd0},
    '{8'h00, 3'd0, 1'b0, 1'b0, 2'd3}
  };

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) baud_tick <= 1'b0;
    else        baud_tick <= ~baud_tick;
  end

  always @(negedge clk) if (rst_n && xfer_done) done_cnt++;

  uart_tx_lin dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_en(cfg_en),
    .cfg_lin_en(cfg_lin_en), .cfg_brk_len(cfg_brk_len), .cfg_data_bits(cfg_data_bits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop_half(cfg_stop_half),
    .cfg_cts_en(cfg_cts_en), .cts(cts), .cfg_ir_en(cfg_ir_en), .cfg_ir_inv(cfg_ir_inv),
    .cfg_free_run(cfg_free_run), .cfg_xfer_len(cfg_xfer_len), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .txd(txd), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input string req);
    int guard = 0;
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) chk(0, req, 0, 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic bit line_at(input bit b, input bit ir, input bit inv);
    return ir ? (inv ^ ~b) : b;
  endfunction

  task automatic rx_char(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                         input int stop_half, input bit ir, input bit inv,
                         input bit meas_stop, input string req);
    bit v;
    bit p;
    int n;
    int exp_l;
    p = podd;
    wait_ticks(8); v = txd; wait_ticks(8);
    chk(v == line_at(0, ir, inv), {req, " start"}, v, line_at(0, ir, inv));
    for (int i = 0; i < nb; i++) begin
      wait_ticks(8); v = txd; wait_ticks(8);
      chk(v == line_at(d[i], ir, inv), {req, " data"}, v, line_at(d[i], ir, inv));
      p ^= d[i];
    end
    if (pen) begin
      wait_ticks(8); v = txd; wait_ticks(8);
      chk(v == line_at(p, ir, inv), "R2 parity", v, line_at(p, ir, inv));
    end
    exp_l = ((stop_half == 0) ? 1 : stop_half) * 8;
    if (meas_stop) begin
      n = 0;
      forever begin
        @(posedge clk);
        if (baud_tick) n++;
        @(negedge clk);
        if (in_ready || xfer_done || n > 200) break;
      end
      chk(n == exp_l, "R3 stop length", n, exp_l);
    end else begin
      wait_ticks(exp_l);
    end
  endtask

  task automatic set_frame(input int nb, input bit pen, input bit podd, input int st);
    cfg_data_bits = 3'(nb - 1);
    cfg_par_en    = pen;
    cfg_par_odd   = podd;
    cfg_stop_half = 2'(st);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    if (!finished_run) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0;
    cfg_en = 0; cfg_lin_en = 0; cfg_brk_len = 3'd4; cfg_data_bits = 3'd7;
    cfg_par_en = 0; cfg_par_odd = 0; cfg_stop_half = 2'd1; cfg_cts_en = 0; cts = 1;
    cfg_ir_en = 0; cfg_ir_inv = 0; cfg_free_run = 0; cfg_xfer_len = 0;
    in_data = 0; in_valid = 0;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1, "R9 reset txd", txd, 1);
    chk(in_ready == 1'b0, "R9 reset ready", in_ready, 0);
    chk(xfer_done == 1'b0, "R9 reset done", xfer_done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3: table of framings
    cfg_free_run = 1; cfg_en = 1;
    foreach (VECS[k]) begin
      set_frame(int'(VECS[k].nb) + 1, VECS[k].pen, VECS[k].podd, int'(VECS[k].stop));
      @(negedge clk);
      send(VECS[k].data, "R1 accept");
      rx_char(VECS[k].data, int'(VECS[k].nb) + 1, VECS[k].pen, VECS[k].podd,
              int'(VECS[k].stop), 0, 0, 1, "R1");
    end

    // R4: LIN header, two break lengths
    for (int s = 0; s < 2; s++) begin
      cfg_en = 0; @(negedge clk); @(negedge clk);
      cfg_lin_en = 1; cfg_brk_len = (s == 0) ? 3'd4 : 3'd7;
      set_frame(8, 1, 0, 2);
      cfg_en = 1; @(negedge clk);
      chk(txd == 1'b0, "R4 break low", txd, 0);
      n = 0;
      while (txd == 1'b0 && n < 400) begin wait_ticks(1); n++; end
      chk(n == (int'(cfg_brk_len) + 8) * 16, "R4 break length", n, (int'(cfg_brk_len) + 8) * 16);
      chk(in_ready == 1'b0, "R4 data blocked", in_ready, 0);
      n = 0;
      while (txd == 1'b1 && n < 100) begin wait_ticks(1); n++; end
      chk(n == 16, "R4 delimiter", n, 16);
      rx_char(8'h55, 8, 1, 0, 2, 0, 0, 1, "R4 sync");
      send(8'hC3, "R4 data after header");
      rx_char(8'hC3, 8, 1, 0, 2, 0, 0, 1, "R4 data");
    end

    // R5: length count
    cfg_en = 0; @(negedge clk); @(negedge clk);
    cfg_lin_en = 0; cfg_free_run = 0; cfg_xfer_len = 16'd3; set_frame(8, 0, 0, 1);
    cfg_en = 1; @(negedge clk);
    done_cnt = 0;
    for (int c = 0; c < 3; c++) begin
      send(8'h10 + 8'(c), "R5 accept");
      rx_char(8'h10 + 8'(c), 8, 0, 0, 1, 0, 0, 1, "R5");
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R5 done pulses", done_cnt, 1);
    in_valid = 1; repeat (50) @(negedge clk);
    chk(in_ready == 1'b0, "R5 blocked after length", in_ready, 0);
    chk(txd == 1'b1, "R5 line idle after length", txd, 1);
    in_valid = 0;
    cfg_en = 0; @(negedge clk); @(negedge clk);
    cfg_en = 1; @(negedge clk);
    chk(in_ready == 1'b1, "R9 count cleared by enable", in_ready, 1);
    cfg_xfer_len = 16'd0; @(negedge clk);
    chk(in_ready == 1'b0, "R5 zero length", in_ready, 0);

    // R6: free run
    cfg_free_run = 1; cfg_xfer_len = 16'd1; done_cnt = 0;
    for (int c = 0; c < 2; c++) begin
      send(8'h5A ^ 8'(c), "R6 accept");
      rx_char(8'h5A ^ 8'(c), 8, 0, 0, 1, 0, 0, 1, "R6");
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == 0, "R6 no done", done_cnt, 0);

    // R7: CTS
    cfg_cts_en = 1; cts = 0; in_data = 8'h96; in_valid = 1;
    repeat (200) @(negedge clk);
    chk(in_ready == 1'b0, "R7 held by cts", in_ready, 0);
    chk(txd == 1'b1, "R7 line idle", txd, 1);
    cts = 1;
    send(8'h96, "R7 accept");
    cts = 0;
    rx_char(8'h96, 8, 0, 0, 1, 0, 0, 0, "R7 completes");
    in_valid = 1; repeat (100) @(negedge clk);
    chk(in_ready == 1'b0, "R7 next held", in_ready, 0);
    in_valid = 0; cts = 1; cfg_cts_en = 0;

    // R8: infrared
    cfg_ir_en = 1; cfg_ir_inv = 0; @(negedge clk); @(negedge clk);
    chk(txd == 1'b0, "R8 ir idle", txd, 0);
    send(8'h00, "R8 accept");
    wait_ticks(7);  chk(txd == 1'b0, "R8 before pulse", txd, 0);
    wait_ticks(1);  chk(txd == 1'b1, "R8 pulse start", txd, 1);
    wait_ticks(2);  chk(txd == 1'b1, "R8 pulse end", txd, 1);
    wait_ticks(1);  chk(txd == 1'b0, "R8 after pulse", txd, 0);
    wait_ticks(5 + 128 + 8);
    @(negedge clk);
    send(8'h0F, "R8 accept");
    rx_char(8'h0F, 8, 0, 0, 1, 1, 0, 1, "R8");
    cfg_ir_inv = 1; @(negedge clk);
    chk(txd == 1'b1, "R8 inverted idle", txd, 1);
    send(8'h3A, "R8 accept inv");
    rx_char(8'h3A, 8, 0, 0, 1, 1, 1, 1, "R8 inv");
    cfg_ir_en = 0; cfg_ir_inv = 0;

    // R9: disable
    cfg_en = 0; @(negedge clk); @(negedge clk);
    chk(txd == 1'b1, "R9 disabled line", txd, 1);
    chk(in_ready == 1'b0, "R9 disabled ready", in_ready, 0);

    finished_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule